// File: doc/BRIEF.md
# Multi-Issue Warp Selector

This block sits in a SIMD core that keeps many warp execution contexts resident at once. Each context stands for 32 threads that run one shared instruction stream in lockstep. On every clock edge the block picks up to four warps for issue, one on each of four issue slots. A context can be picked only while it is allocated and is not waiting on a long-latency memory operation. While one warp waits on memory, the other resident warps keep the execution lanes busy.

The 64 contexts fall into four groups by index modulo 4. Each issue slot serves its own group with a rotating priority pointer, so the four grants in a cycle can never name the same context. Control logic drives four single-index request ports: allocate, free, stall set and stall clear. The block reports its choices on registered grant outputs. Instruction fetch, decode and execution belong to other blocks.

Top module: `warp_issue_select`

## Requirements
- R1: Synchronous active-high reset makes every context invalid, clears every stall bit, sets every rotation pointer to 0 and drives all grant valid bits low.
- R2: An allocate request presented before clock edge E marks the context valid at E. It is first considered for a grant at the following edge E+1, and that grant is visible after E+1.
- R3: Slot s only grants contexts whose index modulo 4 equals s. Its 6-bit index sits in `grant_idx[6*s+5:6*s]`, and its valid bit is `grant_valid[s]`.
- R4: Within its group, slot s scans local positions k = index/4 from its pointer upward, wrapping from 15 to 0, and grants the first eligible one. The pointer then becomes k+1 modulo 16.
- R5: When a slot makes no grant at an edge, its pointer keeps its value.
- R6: A context with its stall bit set is never granted. A stall set request presented before edge E already excludes that context from the decision at E.
- R7: A stall clear request presented before edge E does not make the context eligible at E. It becomes eligible from the decision at E+1.
- R8: A free request presented before edge E excludes that context from the decision at E and clears its valid bit at E. A freed context is never granted afterwards until it is allocated again.
- R9: A slot whose group holds no eligible context drives its grant valid bit low.
- R10: Allocate clears the context's stall bit. A free and an allocate of the same index in one cycle leave it invalid. A stall set and a stall clear of the same index in one cycle leave it stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate request |
| alloc_idx | input | 6 | Context to allocate |
| free_valid | input | 1 | Free request |
| free_idx | input | 6 | Context to free |
| stall_set_valid | input | 1 | Mark a context as waiting on memory |
| stall_set_idx | input | 6 | Context to stall |
| stall_clr_valid | input | 1 | Memory wait done |
| stall_clr_idx | input | 6 | Context to release |
| grant_valid | output | 4 | Per-slot grant valid, registered |
| grant_idx | output | 24 | Per-slot 6-bit granted context index, registered |

## Verification
The bench goes after same-cycle races. If a design let a free or a stall set race past the decision at the same edge, it would issue a warp that is gone or waiting on memory. If it applied a stall clear early, it would issue one cycle too soon. It also checks pointer movement: a pointer that advances on idle cycles, or that lands on the granted position instead of one past it, breaks the expected rotation. An emptied group must report no grant. Request conflicts on one index are checked too, where a wrong priority would leave a freed context valid or a stalled one runnable.

// File: rtl/ws_pkg.sv
package ws_pkg;
  localparam int unsigned WS_NUM_CTX = 64;
  localparam int unsigned WS_NUM_SEL = 4;
endpackage

// File: rtl/ws_ctx_table.sv
module ws_ctx_table #(
  parameter int unsigned NUM_CTX = 64,
  localparam int unsigned IDX_W = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alloc_valid,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic               free_valid,
  input  logic [IDX_W-1:0]   free_idx,
  input  logic               stall_set_valid,
  input  logic [IDX_W-1:0]   stall_set_idx,
  input  logic               stall_clr_valid,
  input  logic [IDX_W-1:0]   stall_clr_idx,
  output logic [NUM_CTX-1:0] elig
);
  logic [NUM_CTX-1:0] valid_q, stall_q;
  logic [NUM_CTX-1:0] alloc_oh, free_oh, set_oh, clr_oh;

  always_comb begin
    alloc_oh = alloc_valid     ? (NUM_CTX'(1) << alloc_idx)     : '0;
    free_oh  = free_valid      ? (NUM_CTX'(1) << free_idx)      : '0;
    set_oh   = stall_set_valid ? (NUM_CTX'(1) << stall_set_idx) : '0;
    clr_oh   = stall_clr_valid ? (NUM_CTX'(1) << stall_clr_idx) : '0;
  end

  // free and stall set act on the decision at this edge; clear does not
  assign elig = valid_q & ~stall_q & ~free_oh & ~set_oh;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      stall_q <= '0;
    end else begin
      valid_q <= (valid_q | alloc_oh) & ~free_oh;
      stall_q <= (stall_q & ~clr_oh & ~alloc_oh) | set_oh;
    end
  end
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int unsigned GROUP = 16,
  localparam int unsigned LW = $clog2(GROUP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GROUP-1:0] elig_grp,
  output logic             gnt_v,
  output logic [LW-1:0]    gnt_k
);
  logic [LW-1:0] ptr_q;
  logic          found;
  logic [LW-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < int'(GROUP); i++) begin
      logic [LW-1:0] k;
      k = LW'((int'(ptr_q) + i) % int'(GROUP));
      if (!found && elig_grp[k]) begin
        found = 1'b1;
        pick  = k;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      gnt_v <= 1'b0;
      gnt_k <= '0;
    end else begin
      gnt_v <= found;
      gnt_k <= pick;
      if (found) ptr_q <= LW'((int'(pick) + 1) % int'(GROUP));
    end
  end
endmodule

// File: rtl/warp_issue_select.sv
module warp_issue_select
  import ws_pkg::*;
#(
  parameter int unsigned NUM_CTX = WS_NUM_CTX,
  parameter int unsigned NUM_SEL = WS_NUM_SEL,
  localparam int unsigned IDX_W = $clog2(NUM_CTX),
  localparam int unsigned SEL_W = $clog2(NUM_SEL),
  localparam int unsigned GROUP = NUM_CTX / NUM_SEL,
  localparam int unsigned LW    = $clog2(GROUP)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     alloc_valid,
  input  logic [IDX_W-1:0]         alloc_idx,
  input  logic                     free_valid,
  input  logic [IDX_W-1:0]         free_idx,
  input  logic                     stall_set_valid,
  input  logic [IDX_W-1:0]         stall_set_idx,
  input  logic                     stall_clr_valid,
  input  logic [IDX_W-1:0]         stall_clr_idx,
  output logic [NUM_SEL-1:0]       grant_valid,
  output logic [NUM_SEL*IDX_W-1:0] grant_idx
);
  logic [NUM_CTX-1:0] elig_w;

  ws_ctx_table #(.NUM_CTX(NUM_CTX)) u_tbl (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .free_valid(free_valid), .free_idx(free_idx),
    .stall_set_valid(stall_set_valid), .stall_set_idx(stall_set_idx),
    .stall_clr_valid(stall_clr_valid), .stall_clr_idx(stall_clr_idx),
    .elig(elig_w)
  );

  for (genvar s = 0; s < int'(NUM_SEL); s++) begin : g_slot
    logic [GROUP-1:0] grp;
    logic [LW-1:0]    k_w;
    for (genvar k = 0; k < int'(GROUP); k++) begin : g_map
      assign grp[k] = elig_w[k*NUM_SEL + s];
    end
    ws_rr_pick #(.GROUP(GROUP)) u_pick (
      .clk(clk), .rst(rst), .elig_grp(grp),
      .gnt_v(grant_valid[s]), .gnt_k(k_w)
    );
    // context index = local position * NUM_SEL + slot
    assign grant_idx[s*IDX_W +: IDX_W] = {k_w, SEL_W'(s)};
  end
endmodule

// File: rtl/ws_sva.sv
module ws_sva #(
  parameter int unsigned NUM_CTX = 64,
  parameter int unsigned NUM_SEL = 4,
  localparam int unsigned IDX_W = $clog2(NUM_CTX),
  localparam int unsigned GROUP = NUM_CTX / NUM_SEL
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     free_valid,
  input logic [IDX_W-1:0]         free_idx,
  input logic [NUM_CTX-1:0]       elig,
  input logic [NUM_SEL-1:0]       grant_valid,
  input logic [NUM_SEL*IDX_W-1:0] grant_idx
);
  logic [NUM_CTX-1:0] elig_d;
  always_ff @(posedge clk) begin
    if (rst) elig_d <= '0;
    else     elig_d <= elig;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> grant_valid == '0);

  for (genvar s = 0; s < int'(NUM_SEL); s++) begin : g_chk
    logic any_d;
    always_comb begin
      any_d = 1'b0;
      for (int k = 0; k < int'(GROUP); k++) any_d = any_d | elig_d[k*NUM_SEL + s];
    end

    assert_grant_eligible_R6: assert property (@(posedge clk) disable iff (rst)
      grant_valid[s] |-> elig_d[grant_idx[s*IDX_W +: IDX_W]]);

    assert_empty_group_R9: assert property (@(posedge clk) disable iff (rst)
      !any_d |-> !grant_valid[s]);

    assert_work_conserving_R4: assert property (@(posedge clk) disable iff (rst)
      any_d |-> grant_valid[s]);

    assert_no_freed_grant_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(free_valid) && grant_valid[s]) |-> grant_idx[s*IDX_W +: IDX_W] != $past(free_idx));
  end
endmodule

bind warp_issue_select ws_sva #(.NUM_CTX(NUM_CTX), .NUM_SEL(NUM_SEL)) u_sva (
  .clk(clk), .rst(rst), .free_valid(free_valid), .free_idx(free_idx),
  .elig(elig_w), .grant_valid(grant_valid), .grant_idx(grant_idx)
);

// File: tb/sim_warp_issue_select.sv
module sim_warp_issue_select;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;
  localparam int S = 4;
  localparam int G = N / S;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_v = 0, f_v = 0, s_v = 0, c_v = 0;
  logic [5:0] a_i = 0, f_i = 0, s_i = 0, c_i = 0;
  logic [S-1:0]   grant_valid;
  logic [S*6-1:0] grant_idx;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mv[N];
  bit ms[N];
  int mp[S];
  bit ev[S];
  int ei[S];

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_select u0 (
    .clk(clk), .rst(rst),
    .alloc_valid(a_v), .alloc_idx(a_i), .free_valid(f_v), .free_idx(f_i),
    .stall_set_valid(s_v), .stall_set_idx(s_i),
    .stall_clr_valid(c_v), .stall_clr_idx(c_i),
    .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  task automatic compare(input string tag);
    for (int s = 0; s < S; s++) begin
      logic [5:0] got;
      got = grant_idx[s*6 +: 6];
      checks++;
      if (grant_valid[s] !== ev[s]) begin
        fails++;
        $display("FAIL %s slot %0d valid: actual %b expected %b", tag, s, grant_valid[s], ev[s]);
      end else if (ev[s] && int'(got) != ei[s]) begin
        fails++;
        $display("FAIL %s slot %0d index: actual %0d expected %0d", tag, s, got, ei[s]);
      end
      if (grant_valid[s] === 1'b1) begin
        checks++;
        if (int'(got) % S != s) begin // R3 group membership
          fails++;
          $display("FAIL R3 slot %0d index modulo: actual %0d expected %0d", s, int'(got) % S, s);
        end
      end
    end
  endtask

  task automatic step(input string tag, input bit av, input int ai, input bit fv, input int fi,
                      input bit sv, input int si, input bit cv, input int ci);
    a_v = av; a_i = 6'(ai); f_v = fv; f_i = 6'(fi);
    s_v = sv; s_i = 6'(si); c_v = cv; c_i = 6'(ci);
    // expected decision from pre-edge state plus same-cycle free / stall set
    for (int s = 0; s < S; s++) begin
      ev[s] = 0; ei[s] = 0;
      for (int i = 0; i < G; i++) begin
        int k, c;
        k = (mp[s] + i) % G;
        c = k * S + s;
        if (!ev[s] && mv[c] && !ms[c] && !(fv && fi == c) && !(sv && si == c)) begin
          ev[s] = 1; ei[s] = c;
        end
      end
      if (ev[s]) mp[s] = (ei[s] / S + 1) % G;
    end
    if (av) begin mv[ai] = 1; ms[ai] = 0; end
    if (fv) mv[fi] = 0;
    if (cv) ms[ci] = 0;
    if (sv) ms[si] = 1;
    @(posedge clk);
    @(negedge clk);
    a_v = 0; f_v = 0; s_v = 0; c_v = 0;
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int c = 0; c < N; c++) begin mv[c] = 0; ms[c] = 0; end
    for (int s = 0; s < S; s++) mp[s] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    for (int s = 0; s < S; s++) begin ev[s] = 0; ei[s] = 0; end
    compare("R1");
    idle("R1", 3);

    step("R2", 1, 9, 0, 0, 0, 0, 0, 0);   // not granted at the edge that allocates it
    idle("R2", 3);                         // then granted repeatedly (only member)
    for (int c = 0; c < N; c++) step("R2", 1, c, 0, 0, 0, 0, 0, 0);
    idle("R4", 40);

    for (int c = 0; c < N; c++)
      if ((c / S) % 2 == 1) step("R6", 0, 0, 0, 0, 1, c, 0, 0);
    idle("R6", 20);

    for (int c = 4; c < N; c += 8) step("R7", 0, 0, 0, 0, 0, 0, 1, c);
    idle("R7", 10);

    for (int c = 2; c < N; c += S) step("R8", 0, 0, 1, c, 0, 0, 0, 0);
    idle("R9", 5);
    step("R5", 1, 42, 0, 0, 0, 0, 0, 0);
    idle("R5", 4);
    step("R5", 1, 10, 0, 0, 0, 0, 0, 0);
    idle("R5", 4);

    step("R10", 1, 3, 1, 3, 0, 0, 0, 0);
    idle("R10", 3);
    step("R10", 0, 0, 0, 0, 1, 0, 1, 0);
    idle("R10", 3);
    step("R10", 1, 7, 0, 0, 0, 0, 0, 0);
    idle("R10", 3);

    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      int r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = int'(lfsr);
      step("R4", lfsr[0], (r >> 1) % N, lfsr[7] & lfsr[8], (r >> 3) % N,
           lfsr[9], (r >> 5) % N, lfsr[10], (r >> 2) % N);
    end
    idle("R4", 5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule